// File: doc/BRIEF.md
# Sign-Magnitude Decimal Sum Checker

This block watches a sign-magnitude decimal adder/subtractor and flags a wrong result magnitude without building a second adder. Each cycle it may take two packed-BCD magnitudes, their signs, an add/subtract request and the magnitude the adder produced. It works out the effective operation from the three sign-related bits. It compares the operands with a digit carry-prefix tree. From these it picks one of three checking paths: plain addition, subtraction with the first magnitude not smaller, or the swapped difference when the first magnitude is smaller.

Per-digit corrections are applied to the operands and to the result digits. Three hexadecimal words result, and their sum must equal the all-ones word when the result is right. One 3:2 carry-save row and a carry-free all-ones test decide the error flag. The block also produces the sign the result should carry. Both outputs appear one clock after the request.

Top module: `sm_bcd_sum_checker`

## Requirements
- R1: While reset is active, and until a request has been accepted after reset, `out_valid`, `sum_err` and `res_sign` are all low.
- R2: A request sampled with `in_valid` high produces `out_valid` high on the next clock edge. A cycle without a request gives `out_valid` low on the next edge and leaves `res_sign` unchanged.
- R3: The effective operation is subtraction exactly when `sign_a ^ sign_b ^ op_sub` is 1. When it is addition, a `mag_res` equal to (`mag_a` + `mag_b`) mod 10^P gives `sum_err` low. This includes sums that overflow P digits.
- R4: When the effective operation is subtraction and `mag_a` >= `mag_b` (including equality), a `mag_res` equal to `mag_a` - `mag_b` gives `sum_err` low.
- R5: When the effective operation is subtraction and `mag_a` < `mag_b`, a `mag_res` equal to `mag_b` - `mag_a` gives `sum_err` low.
- R6: On every path, inverting any single bit of any digit of a correct `mag_res` gives `sum_err` high.
- R7: On every path, any valid BCD `mag_res` that differs from the correct magnitude gives `sum_err` high.
- R8: `res_sign` equals `sign_a`, except when the effective operation is subtraction and `mag_a` < `mag_b`; then it equals the inverse of `sign_a`.
- R9: `sum_err` is low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A check request is present this cycle |
| sign_a | input | 1 | Sign of the first operand (1 = negative) |
| sign_b | input | 1 | Sign of the second operand (1 = negative) |
| op_sub | input | 1 | 1 requests subtraction, 0 addition |
| mag_a | input | 4*P | First magnitude, packed BCD, digit 0 in bits 3:0 |
| mag_b | input | 4*P | Second magnitude, packed BCD |
| mag_res | input | 4*P | Result magnitude produced by the adder under check |
| out_valid | output | 1 | Check outcome present |
| res_sign | output | 1 | Expected sign of the result |
| sum_err | output | 1 | Result magnitude is wrong |

## Verification
The swapped-difference path and the nine-digit result correction can both be active on the same request. This happens when the first magnitude is smaller and shares digits with the second magnitude, so that a borrow runs through equal digit pairs and leaves 9s in the result. In the same vectors the first operand's +6 digit correction also works on the digits where it is larger. Directed vectors built this way are run correct and then with every one of the 4P result bits flipped in turn. The flag must stay low on the correct vector and rise on every flip. Random operands with a forced share of equal magnitudes and equal digits provoke the same overlap on the other two paths.

// File: rtl/sm_bcd_chk_pkg.sv
package sm_bcd_chk_pkg;
  typedef logic [3:0] nib_t;

  localparam nib_t NIB_SIX  = 4'd6;
  localparam nib_t NIB_NINE = 4'd9;
  localparam nib_t NIB_ALL  = 4'hF;

  // Checking path chosen for one request
  typedef enum logic [1:0] {
    PATH_ADD  = 2'd0,
    PATH_DIFF = 2'd1,
    PATH_SWAP = 2'd2
  } path_e;
endpackage

// File: rtl/sm_bcd_digit_prep.sv
// One digit: biased or complemented second operand, plus its
// generate / transmit flags for the digit prefix tree.
module sm_bcd_digit_prep
  import sm_bcd_chk_pkg::*;
(
  input  nib_t x_dig,
  input  nib_t y_dig,
  input  logic eff_sub,
  output nib_t ya_dig,
  output logic gen_o,
  output logic trn_o
);
  logic [4:0] pair_sum;

  always_comb begin
    ya_dig   = eff_sub ? ~y_dig : (y_dig + NIB_SIX);
    pair_sum = {1'b0, x_dig} + {1'b0, ya_dig};
    gen_o    = pair_sum >= 5'd16;
    trn_o    = pair_sum >= 5'd15;
  end
endmodule

// File: rtl/sm_bcd_prefix.sv
// Log-depth carry-prefix over digit generate/transmit pairs.
module sm_bcd_prefix #(
  parameter int P = 16
) (
  input  logic [P-1:0] gen_i,
  input  logic [P-1:0] trn_i,
  input  logic         cin,
  output logic         cout
);
  localparam int LV = (P > 1) ? $clog2(P) : 1;

  logic [LV:0][P-1:0] gl;
  logic [LV:0][P-1:0] tl;

  assign gl[0] = gen_i;
  assign tl[0] = trn_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int SPAN = 1 << l;
    for (genvar i = 0; i < P; i++) begin : g_dig
      if (i >= SPAN) begin : g_merge
        assign gl[l+1][i] = gl[l][i] | (tl[l][i] & gl[l][i-SPAN]);
        assign tl[l+1][i] = tl[l][i] & tl[l][i-SPAN];
      end else begin : g_pass
        assign gl[l+1][i] = gl[l][i];
        assign tl[l+1][i] = tl[l][i];
      end
    end
  end

  assign cout = gl[LV][P-1] | (tl[LV][P-1] & cin);
endmodule

// File: rtl/sm_bcd_digit_fix.sv
// One digit: the three corrected compressor inputs for the active path.
module sm_bcd_digit_fix
  import sm_bcd_chk_pkg::*;
(
  input  nib_t x_dig,
  input  nib_t ya_dig,
  input  nib_t s_dig,
  input  logic gen_i,
  input  logic trn_i,
  input  logic swap,
  output nib_t op_x,
  output nib_t op_y,
  output nib_t op_s
);
  logic nine_fix;
  nib_t s_adj;

  always_comb begin
    // drop the +6 bias where the digit cannot carry out (normal paths)
    op_y     = (!trn_i && !swap) ? (ya_dig - NIB_SIX) : ya_dig;
    // swapped difference: rebias first operand where it produced a carry
    op_x     = (swap && gen_i) ? (x_dig + NIB_SIX) : x_dig;
    // transmit-only digit: a 9 in the result stands for hex 15
    nine_fix = trn_i && !gen_i && (s_dig == NIB_NINE);
    s_adj    = nine_fix ? NIB_ALL : s_dig;
    op_s     = swap ? s_adj : ~s_adj;
  end
endmodule

// File: rtl/sm_bcd_csa_check.sv
// 3:2 carry-save row followed by a carry-free all-ones test.
module sm_bcd_csa_check #(
  parameter int W = 64
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         cin,
  output logic         mism
);
  logic [W-1:0] sv;
  logic [W-1:0] cv;
  logic [W-1:0] cv_sh;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign sv[k] = in_a[k] ^ in_b[k] ^ in_c[k];
    assign cv[k] = (in_a[k] & in_b[k]) | (in_c[k] & (in_a[k] | in_b[k]));
  end

  if (W > 1) begin : g_sh
    assign cv_sh = {cv[W-2:0], cin};
  end else begin : g_sh1
    assign cv_sh = cin;
  end

  assign mism = ~&(sv ^ cv_sh);
endmodule

// File: rtl/sm_bcd_sum_checker.sv
module sm_bcd_sum_checker
  import sm_bcd_chk_pkg::*;
#(
  parameter int P = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           sign_a,
  input  logic           sign_b,
  input  logic           op_sub,
  input  logic [4*P-1:0] mag_a,
  input  logic [4*P-1:0] mag_b,
  input  logic [4*P-1:0] mag_res,
  output logic           out_valid,
  output logic           res_sign,
  output logic           sum_err
);
  localparam int W = 4 * P;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  // effective operation and digit preparation
  logic         eff_sub;
  logic [W-1:0] ya_vec;
  logic [P-1:0] gen_v;
  logic [P-1:0] trn_v;

  assign eff_sub = sign_a ^ sign_b ^ op_sub;

  for (genvar i = 0; i < P; i++) begin : g_prep
    sm_bcd_digit_prep u_prep (
      .x_dig  (mag_a[4*i +: 4]),
      .y_dig  (mag_b[4*i +: 4]),
      .eff_sub(eff_sub),
      .ya_dig (ya_vec[4*i +: 4]),
      .gen_o  (gen_v[i]),
      .trn_o  (trn_v[i])
    );
  end

  // magnitude comparison: carry out with eff_sub as carry-in
  logic  cmp_cout;
  logic  swap;
  logic  csa_cin;
  path_e path;

  sm_bcd_prefix #(.P(P)) u_prefix (
    .gen_i(gen_v),
    .trn_i(trn_v),
    .cin  (eff_sub),
    .cout (cmp_cout)
  );

  always_comb begin
    if (!eff_sub)      path = PATH_ADD;
    else if (cmp_cout) path = PATH_DIFF;
    else               path = PATH_SWAP;
    swap    = (path == PATH_SWAP);
    csa_cin = (path == PATH_DIFF);
  end

  // per-digit corrections
  logic [W-1:0] op_x;
  logic [W-1:0] op_y;
  logic [W-1:0] op_s;

  for (genvar i = 0; i < P; i++) begin : g_fix
    sm_bcd_digit_fix u_fix (
      .x_dig (mag_a[4*i +: 4]),
      .ya_dig(ya_vec[4*i +: 4]),
      .s_dig (mag_res[4*i +: 4]),
      .gen_i (gen_v[i]),
      .trn_i (trn_v[i]),
      .swap  (swap),
      .op_x  (op_x[4*i +: 4]),
      .op_y  (op_y[4*i +: 4]),
      .op_s  (op_s[4*i +: 4])
    );
  end

  logic mism;

  sm_bcd_csa_check #(.W(W)) u_csa (
    .in_a(op_x),
    .in_b(op_y),
    .in_c(op_s),
    .cin (csa_cin),
    .mism(mism)
  );

  // next state
  logic vld_d, err_d, sgn_d;
  logic vld_q, err_q, sgn_q;

  always_comb begin
    vld_d = in_valid;
    err_d = in_valid & mism;
    sgn_d = in_valid ? (sign_a ^ swap) : sgn_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      sgn_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      sgn_q <= sgn_d;
    end
  end

  assign out_valid = vld_q;
  assign sum_err   = err_q;
  assign res_sign  = sgn_q;

  // assertions
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);

  assert_sign_held_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(res_sign));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_valid |-> !sum_err);

  // equal magnitudes under subtraction never take the swapped path
  assert_equal_no_swap_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (sign_a ^ sign_b ^ op_sub) && (mag_a == mag_b)) |-> !swap);

  assert_add_sign_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !(sign_a ^ sign_b ^ op_sub)) |=> (res_sign == $past(sign_a)));
endmodule

// File: tb/sm_bcd_sum_checker_test.sv
`timescale 1ns/1ps
module sm_bcd_sum_checker_test;
  localparam int P = 16;
  localparam int W = 4 * P;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         sign_a, sign_b, op_sub;
  logic [W-1:0] mag_a, mag_b, mag_res;
  logic         out_valid, res_sign, sum_err;

  int n_chk;
  int n_fail;

  sm_bcd_sum_checker #(.P(P)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .sign_a(sign_a), .sign_b(sign_b), .op_sub(op_sub),
    .mag_a(mag_a), .mag_b(mag_b), .mag_res(mag_res),
    .out_valid(out_valid), .res_sign(res_sign), .sum_err(sum_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference arithmetic on packed BCD
  function automatic logic [W-1:0] bcd_add(logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] r;
    int c;
    c = 0;
    r = '0;
    for (int d = 0; d < P; d++) begin
      int t;
      t = int'(x[4*d +: 4]) + int'(y[4*d +: 4]) + c;
      c = (t >= 10) ? 1 : 0;
      r[4*d +: 4] = 4'(t - 10 * c);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bcd_sub(logic [W-1:0] x, logic [W-1:0] y);
    logic [W-1:0] r;
    int b;
    b = 0;
    r = '0;
    for (int d = 0; d < P; d++) begin
      int t;
      t = int'(x[4*d +: 4]) - int'(y[4*d +: 4]) - b;
      b = (t < 0) ? 1 : 0;
      r[4*d +: 4] = 4'(t + 10 * b);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_mag(logic sa, logic sb, logic sub,
                                           logic [W-1:0] x, logic [W-1:0] y);
    if (!(sa ^ sb ^ sub)) return bcd_add(x, y);
    if (x >= y)           return bcd_sub(x, y);
    return bcd_sub(y, x);
  endfunction

  function automatic logic ref_sign(logic sa, logic sb, logic sub,
                                    logic [W-1:0] x, logic [W-1:0] y);
    if ((sa ^ sb ^ sub) && (x < y)) return ~sa;
    return sa;
  endfunction

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] r;
    for (int d = 0; d < P; d++) r[4*d +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run(logic sa, logic sb, logic sub, logic [W-1:0] x,
                     logic [W-1:0] y, logic [W-1:0] s, logic exp_err, string req);
    in_valid = 1'b1;
    sign_a = sa; sign_b = sb; op_sub = sub;
    mag_a = x; mag_b = y; mag_res = s;
    @(negedge clk);
    chk("R2", W'(out_valid), W'(1'b1), "out_valid");
    chk(req, W'(sum_err), W'(exp_err), "sum_err");
    chk("R8", W'(res_sign), W'(ref_sign(sa, sb, sub, x, y)), "res_sign");
    in_valid = 1'b0;
  endtask

  task automatic run_good_and_flips(logic sa, logic sb, logic sub,
                                    logic [W-1:0] x, logic [W-1:0] y, string req);
    logic [W-1:0] s;
    s = ref_mag(sa, sb, sub, x, y);
    run(sa, sb, sub, x, y, s, 1'b0, req);
    for (int b = 0; b < W; b++)
      run(sa, sb, sub, x, y, s ^ (W'(1) << b), 1'b1, "R6");
  endtask

  logic done;

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic held;
    n_chk = 0;
    n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0;
    sign_a = 1'b0; sign_b = 1'b0; op_sub = 1'b0;
    mag_a = '0; mag_b = '0; mag_res = '0;
    repeat (3) @(negedge clk);
    chk("R1", W'(out_valid), '0, "out_valid in reset");
    chk("R1", W'(sum_err), '0, "sum_err in reset");
    chk("R1", W'(res_sign), '0, "res_sign in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", W'(out_valid), '0, "out_valid after reset");
    chk("R1", W'(sum_err), '0, "sum_err after reset");
    chk("R1", W'(res_sign), '0, "res_sign after reset");

    // R3: addition, overflow wraps mod 10^P
    run(1'b0, 1'b0, 1'b0, {P{4'h9}}, W'(1), '0, 1'b0, "R3");
    run(1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_4567, 64'h0000_0000_0000_5433,
        64'h0000_0000_0001_0000, 1'b0, "R3");
    // R9 / R2: idle cycle after a request, sign held
    held = res_sign;
    @(negedge clk);
    chk("R2", W'(out_valid), '0, "out_valid idle");
    chk("R9", W'(sum_err), '0, "sum_err idle");
    chk("R2", W'(res_sign), W'(held), "res_sign held");

    // R4: equal magnitudes, and all-nines minus one
    run(1'b0, 1'b0, 1'b1, 64'h0000_0000_0098_7654, 64'h0000_0000_0098_7654,
        '0, 1'b0, "R4");
    run(1'b1, 1'b1, 1'b1, {P{4'h9}}, W'(1), {{(P-1){4'h9}}, 4'h8}, 1'b0, "R4");
    // R5: swapped difference with borrow through equal digits (result 0997)
    run(1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0123, 64'h0000_0000_0000_1120,
        64'h0000_0000_0000_0997, 1'b0, "R5");
    // R7: wrong path result (ten's complement instead of swapped difference)
    run(1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0123, 64'h0000_0000_0000_1120,
        bcd_sub(64'h0000_0000_0000_0123, 64'h0000_0000_0000_1120), 1'b1, "R7");

    // R6: every bit flipped on each path
    run_good_and_flips(1'b0, 1'b1, 1'b1, 64'h0987_6543_2109_8765,
                       64'h0123_4567_8901_2345, "R3");
    run_good_and_flips(1'b0, 1'b0, 1'b1, 64'h5555_4321_0099_1234,
                       64'h5555_1234_0099_1230, "R4");
    run_good_and_flips(1'b1, 1'b0, 1'b0, 64'h0000_1234_5599_0123,
                       64'h0000_1234_6600_1120, "R5");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic sa, sb, sub;
      logic [W-1:0] x, y, s, wrong;
      int sel;
      sa = 1'($urandom); sb = 1'($urandom); sub = 1'($urandom);
      x = rand_bcd();
      y = rand_bcd();
      sel = $urandom % 6;
      if (sel == 0) y = x;
      else if (sel == 1) begin
        for (int d = 0; d < P; d++)
          if ($urandom % 2 == 0) y[4*d +: 4] = x[4*d +: 4];
      end
      s = ref_mag(sa, sb, sub, x, y);
      run(sa, sb, sub, x, y, s, 1'b0, (sa ^ sb ^ sub) ? ((x >= y) ? "R4" : "R5") : "R3");
      run(sa, sb, sub, x, y, s ^ (W'(1) << ($urandom % W)), 1'b1, "R6");
      wrong = rand_bcd();
      if (wrong == s) wrong[3:0] = (s[3:0] == 4'd9) ? 4'd0 : s[3:0] + 4'd1;
      run(sa, sb, sub, x, y, wrong, 1'b1, "R7");
    end

    @(negedge clk);
    chk("R9", W'(sum_err), '0, "sum_err at end");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule